// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. It leaves reset owning the row and column strobes and holds both high through the mandatory start-up pause. It then runs a fixed number of row-strobe-only wake-up pulses, with the column strobe held high. After that it hands the strobes back and works as a refresh scheduler. An interval timer spreads refreshes evenly, so that the full set of rows is visited once per refresh period. Each refresh is a column-before-row (CBR) cycle, which uses the device's internal row counter. A parameter selects the refresh period: 8 ms for the standard device and 64 ms for the extended-refresh device.

The block shares the strobes with an access controller through a request/grant pair. A timer expiry adds one refresh to a backlog and raises `ref_req`. When `ref_grant` is seen, the block takes the strobes and runs one CBR cycle for each backlog entry. Each cycle is framed by precharge time on both sides. If the controller withholds the grant until the backlog passes a limit, the refresh deadline counts as missed. The block then raises `busy` and refuses host requests. On the next grant it repeats the wake-up pulses in place of the refresh cycles, clears the backlog and restarts the interval.

The strobe engine is one state machine with these states:
- S_PAUSE: the start-up wait.
- S_ARM: the strobes are taken and both are held high for precharge.
- S_WAKE_LO and S_WAKE_HI: a wake-up pulse and its precharge.
- S_IDLE: the strobes are released.
- S_CSR: the column strobe is low and the row strobe is still high.
- S_RAS: both strobes are low.
- S_REC: both strobes are high again as recovery.

Its transitions are:
- S_PAUSE to S_WAKE_LO when the pause ends.
- S_WAKE_LO to S_WAKE_HI, then S_WAKE_HI back to S_WAKE_LO while pulses remain, or to S_IDLE after the last pulse.
- S_IDLE to S_ARM on backlog plus grant.
- S_ARM to S_WAKE_LO when a re-wake is pending, otherwise S_ARM to S_CSR.
- S_CSR to S_RAS, S_RAS to S_REC, and S_REC to S_IDLE.

Top module: `dram_ref_seq`

## Requirements
- R1: While reset is held, and through the start-up pause after it, ras_n and cas_n are 1, bus_own and busy are 1, and ref_req is 0. The pause lasts PAUSE_NS/CLK_NS cycles (20000 at the defaults) from reset release until the first ras_n fall.
- R2: After the pause, exactly WAKE_CYCLES (8) row-only pulses follow. During them cas_n stays 1. busy falls to 0 after the last pulse, and no CBR cycle occurs before that.
- R3: With EXTENDED=0, successive refresh cycles start 8 ms/512 apart. At 5 ns per clock that is 3125 cycles between ras_n falls, when the grant is always given.
- R4: With EXTENDED=1, the spacing is 64 ms/512 = 125 µs, which is 25000 cycles.
- R5: In a refresh cycle, cas_n falls while ras_n is 1, at least tCSR (2 cycles) before ras_n falls. ras_n stays low for at least max(tRAS, tCHR) (12 cycles). cas_n never rises while ras_n is 0.
- R6: Whenever the block takes or gives back the strobes, both are high for at least max(tRP, tCPN) (8 cycles) beforehand. Every ras_n high phase between pulses is at least 8 cycles.
- R7: A strobe edge occurs only while bus_own=1. bus_own rises only in the cycle after ref_grant=1. ref_req=1 while the backlog is non-zero and the strobes are released.
- R8: Up to MISS_LIMIT (2) timer expiries may accumulate while the grant is withheld, and busy stays 0. On grant, exactly that many CBR cycles run, after which ref_req=0.
- R9: If the backlog passes MISS_LIMIT, busy rises. On the next grant, WAKE_CYCLES row-only pulses run with no pause and no CBR cycle. busy then falls, ref_req is 0, and the next refresh begins one interval (3125 cycles, up to 40 cycles later) after busy falls.
- R10: host_accept equals host_req while busy=0, and is 0 while busy=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_grant | input | 1 | Access controller has released the strobes |
| host_req | input | 1 | Host asks to start an access |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| bus_own | output | 1 | Sequencer is driving the strobes |
| ref_req | output | 1 | Refresh backlog waiting for a grant |
| busy | output | 1 | Wake-up sequence running or pending |
| host_accept | output | 1 | Host request accepted |

## Verification
The refresh scheduler is exercised with four grant patterns. A grant held high throughout shows the exact even spacing for both period settings. A grant withheld over two expiries shows that a backlog under the limit is drained as back-to-back CBR cycles without a re-wake. A grant withheld over three expiries separates the re-wake path from plain refresh: the pulses are row-only, the backlog is cleared and the interval restarts. A monitor on the strobes checks every column-before-row lead, pulse width and precharge gap across all of these patterns, so an ordering fault shows up whichever path produced the pulse.

// File: rtl/dram_ref_pkg.sv
`timescale 1ns/1ps
package dram_ref_pkg;
    typedef enum logic [2:0] {
        S_PAUSE,
        S_ARM,
        S_WAKE_LO,
        S_WAKE_HI,
        S_IDLE,
        S_CSR,
        S_RAS,
        S_REC
    } seq_state_t;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/dram_ref_timer.sv
`timescale 1ns/1ps
module dram_ref_timer #(
    parameter int INTERVAL_CYC = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL_CYC);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = en && !clr && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    // R3: expiries are never adjacent
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dram_ref_backlog.sv
`timescale 1ns/1ps
module dram_ref_backlog #(
    parameter int MISS_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic done,
    input  logic clr,
    output logic pending_nz,
    output logic need_wake
);
    localparam int PW = $clog2(MISS_LIMIT + 2);
    localparam logic [PW-1:0] CAP = PW'(MISS_LIMIT + 1);

    logic [PW-1:0] pending;

    assign pending_nz = (pending != '0);
    assign need_wake  = (pending > PW'(MISS_LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (clr) begin
            pending <= '0;
        end else begin
            unique case ({tick && (pending != CAP), done && (pending != '0)})
                2'b10:   pending <= pending + 1'b1;
                2'b01:   pending <= pending - 1'b1;
                default: pending <= pending;
            endcase
        end
    end

    // R8: backlog bounded by the re-wake limit
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= CAP);
    // R7: a finished refresh always has work to retire
    p_done_has_work_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pending != '0);
endmodule

// File: rtl/dram_ref_fsm.sv
`timescale 1ns/1ps
module dram_ref_fsm
    import dram_ref_pkg::*;
#(
    parameter int PAUSE_CYC   = 20000,
    parameter int RAS_CYC     = 12,
    parameter int PRE_CYC     = 8,
    parameter int CSR_CYC     = 2,
    parameter int WAKE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending_nz,
    input  logic need_wake,
    input  logic ref_grant,
    output logic ras_n,
    output logic cas_n,
    output logic bus_own,
    output logic busy,
    output logic ref_req,
    output logic ref_done,
    output logic wake_done,
    output logic wake_active
);
    localparam int MAXLEN = imax(imax(PAUSE_CYC, RAS_CYC), imax(PRE_CYC, CSR_CYC));
    localparam int SW = $clog2(MAXLEN + 1);
    localparam int WW = $clog2(WAKE_CYCLES + 1);

    seq_state_t state, state_nx;
    logic [SW-1:0] seg;
    logic [WW-1:0] wake_left;
    logic arm_wake;

    function automatic logic [SW-1:0] seg_len(input seq_state_t s);
        unique case (s)
            S_PAUSE:   return SW'(PAUSE_CYC - 1);
            S_ARM:     return SW'(PRE_CYC - 1);
            S_WAKE_LO: return SW'(RAS_CYC - 1);
            S_WAKE_HI: return SW'(PRE_CYC - 1);
            S_CSR:     return SW'(CSR_CYC - 1);
            S_RAS:     return SW'(RAS_CYC - 1);
            S_REC:     return SW'(PRE_CYC - 1);
            default:   return '0;
        endcase
    endfunction

    assign ref_done    = (state == S_REC) && (seg == '0);
    assign wake_done   = (state == S_WAKE_HI) && (seg == '0) && (wake_left == '0);
    assign wake_active = (state == S_PAUSE) || (state == S_WAKE_LO) || (state == S_WAKE_HI);
    assign ref_req     = (state == S_IDLE) && pending_nz;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_PAUSE:   if (seg == '0) state_nx = S_WAKE_LO;
            S_ARM:     if (seg == '0) state_nx = arm_wake ? S_WAKE_LO : S_CSR;
            S_WAKE_LO: if (seg == '0) state_nx = S_WAKE_HI;
            S_WAKE_HI: if (seg == '0) state_nx = (wake_left == '0) ? S_IDLE : S_WAKE_LO;
            S_IDLE:    if (pending_nz && ref_grant) state_nx = S_ARM;
            S_CSR:     if (seg == '0) state_nx = S_RAS;
            S_RAS:     if (seg == '0) state_nx = S_REC;
            S_REC:     if (seg == '0) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // state register, segment timer and wake-up pulse counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_PAUSE;
            seg       <= SW'(PAUSE_CYC - 1);
            wake_left <= WW'(WAKE_CYCLES - 1);
            arm_wake  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx != state) seg <= seg_len(state_nx);
            else if (seg != '0)    seg <= seg - 1'b1;
            if (state == S_IDLE && state_nx == S_ARM) begin
                arm_wake  <= need_wake;
                wake_left <= WW'(WAKE_CYCLES - 1);
            end else if (state == S_WAKE_HI && state_nx == S_WAKE_LO) begin
                wake_left <= wake_left - 1'b1;
            end
        end
    end

    // registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_n   <= 1'b1;
            cas_n   <= 1'b1;
            bus_own <= 1'b1;
            busy    <= 1'b1;
        end else begin
            ras_n   <= !(state_nx == S_WAKE_LO || state_nx == S_RAS);
            cas_n   <= !(state_nx == S_CSR || state_nx == S_RAS);
            bus_own <= (state_nx != S_IDLE);
            busy    <= (state_nx == S_PAUSE || state_nx == S_WAKE_LO ||
                        state_nx == S_WAKE_HI) || (need_wake && !wake_done);
        end
    end

    // strobe run-length counters used only by the checks below
    logic [SW-1:0] ras_lo_cnt, cas_lo_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo_cnt <= '0;
            cas_lo_cnt <= '0;
        end else begin
            if (ras_n) ras_lo_cnt <= '0;
            else if (ras_lo_cnt != '1) ras_lo_cnt <= ras_lo_cnt + 1'b1;
            if (cas_n) cas_lo_cnt <= '0;
            else if (cas_lo_cnt != '1) cas_lo_cnt <= cas_lo_cnt + 1'b1;
        end
    end

    // R5: column strobe leads, never trails
    p_cas_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ras_n);
    p_cas_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> ras_n);
    p_csr_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> cas_lo_cnt >= SW'(CSR_CYC));
    p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> ras_lo_cnt >= SW'(RAS_CYC));
    // R2: wake-up pulses run only while busy is shown
    p_busy_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAKE_LO) |-> busy);
    // R7: no strobe edge while released
    p_quiet_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (ras_n && cas_n));
endmodule

// File: rtl/dram_ref_seq.sv
`timescale 1ns/1ps
module dram_ref_seq
    import dram_ref_pkg::*;
#(
    parameter int CLK_NS        = 5,
    parameter int EXTENDED      = 0,
    parameter int ROWS          = 512,
    parameter int STD_PERIOD_NS = 8_000_000,
    parameter int EXT_PERIOD_NS = 64_000_000,
    parameter int PAUSE_NS      = 100_000,
    parameter int WAKE_CYCLES   = 8,
    parameter int MISS_LIMIT    = 2,
    parameter int TRAS_NS       = 60,
    parameter int TRP_NS        = 40,
    parameter int TCSR_NS       = 10,
    parameter int TCHR_NS       = 10,
    parameter int TCPN_NS       = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_grant,
    input  logic host_req,
    output logic ras_n,
    output logic cas_n,
    output logic bus_own,
    output logic ref_req,
    output logic busy,
    output logic host_accept
);
    localparam int PERIOD_NS    = (EXTENDED != 0) ? EXT_PERIOD_NS : STD_PERIOD_NS;
    localparam int INTERVAL_CYC = PERIOD_NS / ROWS / CLK_NS;
    localparam int PAUSE_CYC    = ns_to_cyc(PAUSE_NS, CLK_NS);
    localparam int RAS_CYC      = imax(ns_to_cyc(TRAS_NS, CLK_NS), ns_to_cyc(TCHR_NS, CLK_NS));
    localparam int PRE_CYC      = imax(ns_to_cyc(TRP_NS, CLK_NS), ns_to_cyc(TCPN_NS, CLK_NS));
    localparam int CSR_CYC      = ns_to_cyc(TCSR_NS, CLK_NS);

    logic tick, ref_done, wake_done, wake_active, pending_nz, need_wake;

    dram_ref_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (!wake_active && !need_wake),
        .clr  (wake_done),
        .tick (tick)
    );

    dram_ref_backlog #(.MISS_LIMIT(MISS_LIMIT)) u_backlog (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .done      (ref_done),
        .clr       (wake_done),
        .pending_nz(pending_nz),
        .need_wake (need_wake)
    );

    dram_ref_fsm #(
        .PAUSE_CYC  (PAUSE_CYC),
        .RAS_CYC    (RAS_CYC),
        .PRE_CYC    (PRE_CYC),
        .CSR_CYC    (CSR_CYC),
        .WAKE_CYCLES(WAKE_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending_nz (pending_nz),
        .need_wake  (need_wake),
        .ref_grant  (ref_grant),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .bus_own    (bus_own),
        .busy       (busy),
        .ref_req    (ref_req),
        .ref_done   (ref_done),
        .wake_done  (wake_done),
        .wake_active(wake_active)
    );

    assign host_accept = host_req && !busy;

    // R7: strobes are taken only after a grant
    p_take_on_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> $past(ref_grant));
    // R10: a busy sequencer refuses the host
    p_refuse_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_req) |-> !host_accept);
endmodule

// File: tb/sim_dram_ref_seq.sv
`timescale 1ns/1ps
module sim_dram_ref_seq;
    localparam int PAUSE = 20000;
    localparam int INTV  = 3125;
    localparam int INTX  = 25000;
    localparam int RASW  = 12;
    localparam int PREW  = 8;
    localparam int CSRW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b1;
    logic hreq = 1'b0;
    logic ras_n, cas_n, own, req, busy, hacc;
    logic x_ras_n, x_cas_n, x_own, x_req, x_busy, x_hacc;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_ref_seq u0 (
        .clk(clk), .rst_n(rst_n), .ref_grant(gnt), .host_req(hreq),
        .ras_n(ras_n), .cas_n(cas_n), .bus_own(own), .ref_req(req),
        .busy(busy), .host_accept(hacc)
    );

    dram_ref_seq #(.EXTENDED(1)) u1 (
        .clk(clk), .rst_n(rst_n), .ref_grant(1'b1), .host_req(1'b0),
        .ras_n(x_ras_n), .cas_n(x_cas_n), .bus_own(x_own), .ref_req(x_req),
        .busy(x_busy), .host_accept(x_hacc)
    );

    // strobe monitor for u0
    logic p_ras = 1'b1, p_cas = 1'b1, p_own = 1'b1;
    int ras_hi = 0, ras_lo = 0, cas_lo = 0;
    int n_cbr = 0, n_ronly = 0, t_cbr_last = 0, t_cbr_prev = 0;
    int bad_csr = 0, bad_rasw = 0, bad_pre = 0, bad_casrise = 0, bad_own = 0, bad_rel = 0;
    int x_cbr = 0, x_t0 = 0, x_t1 = 0;
    logic xp_ras = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                if (!cas_n) begin
                    n_cbr++; t_cbr_prev = t_cbr_last; t_cbr_last = cyc;
                    if (cas_lo < CSRW) bad_csr++;
                end else n_ronly++;
                if (ras_hi < PREW) bad_pre++;
                if (!own) bad_own++;
            end
            if (!p_ras && ras_n && ras_lo < RASW) bad_rasw++;
            if (!p_cas && cas_n && !ras_n) bad_casrise++;
            if (!p_cas && cas_n && !own) bad_own++;
            if (p_own && !own && ras_hi < PREW) bad_rel++;
            if (!p_own && own && !(ras_n && cas_n)) bad_pre++;
            ras_hi = ras_n ? ras_hi + 1 : 0;
            ras_lo = ras_n ? 0 : ras_lo + 1;
            cas_lo = cas_n ? 0 : cas_lo + 1;
            p_ras = ras_n; p_cas = cas_n; p_own = own;
            if (xp_ras && !x_ras_n && !x_cas_n) begin
                x_cbr++; x_t0 = x_t1; x_t1 = cyc;
            end
            xp_ras = x_ras_n;
        end
    end

    task automatic chk(input string rq, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_rules();
        chk("R5 cas lead", bad_csr == 0, bad_csr, 0);
        chk("R5 ras width", bad_rasw == 0, bad_rasw, 0);
        chk("R5 cas rise under ras", bad_casrise == 0, bad_casrise, 0);
        chk("R6 precharge", bad_pre == 0, bad_pre, 0);
        chk("R6 release gap", bad_rel == 0, bad_rel, 0);
        chk("R7 strobe without ownership", bad_own == 0, bad_own, 0);
    endtask

    task automatic t_reset();
        hreq = 1'b1;
        idle(4);
        chk("R1 ras_n in reset", ras_n == 1'b1, ras_n, 1);
        chk("R1 cas_n in reset", cas_n == 1'b1, cas_n, 1);
        chk("R1 busy in reset", busy == 1'b1, busy, 1);
        chk("R1 bus_own in reset", own == 1'b1, own, 1);
        chk("R1 ref_req in reset", req == 1'b0, req, 0);
        chk("R10 refused in reset", hacc == 1'b0, hacc, 0);
    endtask

    task automatic t_powerup();
        int rel, fall;
        rst_n = 1'b1;
        rel = cyc;
        idle(PAUSE / 2);
        chk("R1 quiet mid pause", ras_n && cas_n && busy && !req, ras_n, 1);
        while (ras_n) @(negedge clk);
        fall = cyc - rel;
        chk("R1 pause length", fall >= PAUSE && fall <= PAUSE + 1, fall, PAUSE);
        while (busy) @(negedge clk);
        chk("R2 wake pulse count", n_ronly == 8, n_ronly, 8);
        chk("R2 no refresh during wake", n_cbr == 0, n_cbr, 0);
        chk("R7 released after wake", own == 1'b0, own, 0);
        chk("R10 accepted when idle", hacc == 1'b1, hacc, 1);
        hreq = 1'b0;
    endtask

    task automatic t_interval();
        while (n_cbr < 2) @(negedge clk);
        chk("R3 standard spacing", t_cbr_last - t_cbr_prev == INTV, t_cbr_last - t_cbr_prev, INTV);
        while (own) @(negedge clk);
    endtask

    task automatic t_small_backlog();
        int c0, owned;
        gnt = 1'b0;
        c0 = n_cbr;
        owned = 0;
        while (!req) @(negedge clk);
        for (int i = 0; i < INTV + 75; i++) begin
            @(negedge clk);
            if (own) owned++;
        end
        chk("R7 no takeover without grant", owned == 0, owned, 0);
        chk("R8 busy stays low under limit", busy == 1'b0, busy, 0);
        chk("R7 request held", req == 1'b1, req, 1);
        gnt = 1'b1;
        idle(200);
        chk("R8 backlog drained", n_cbr == c0 + 2, n_cbr - c0, 2);
        chk("R8 request cleared", req == 1'b0, req, 0);
    endtask

    task automatic t_rewake();
        int c0, r0, tb, dt;
        gnt = 1'b0;
        while (!req) @(negedge clk);
        idle(2 * INTV + 100);
        chk("R9 busy after missed deadline", busy == 1'b1, busy, 1);
        hreq = 1'b1;
        @(negedge clk);
        chk("R10 host refused", hacc == 1'b0, hacc, 0);
        c0 = n_cbr; r0 = n_ronly;
        gnt = 1'b1;
        while (busy) @(negedge clk);
        tb = cyc;
        chk("R9 rewake pulse count", n_ronly == r0 + 8, n_ronly - r0, 8);
        chk("R9 no refresh in rewake", n_cbr == c0, n_cbr - c0, 0);
        chk("R9 backlog cleared", req == 1'b0, req, 0);
        chk("R10 host accepted again", hacc == 1'b1, hacc, 1);
        hreq = 1'b0;
        while (n_cbr == c0) @(negedge clk);
        dt = t_cbr_last - tb;
        chk("R9 interval restarted", dt >= INTV && dt <= INTV + 40, dt, INTV);
    endtask

    task automatic t_extended();
        while (x_cbr < 2) @(negedge clk);
        chk("R4 extended spacing", x_t1 - x_t0 == INTX, x_t1 - x_t0, INTX);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_interval();
        t_small_backlog();
        t_rewake();
        t_extended();
        strobe_rules();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end
endmodule